// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block sits beside the instruction memory in the fetch stage. Each fetch address is looked up in a direct-mapped table at the same clock edge that starts the instruction read, and the answer is ready in the following cycle, when the fetched word also arrives. If the table holds a valid entry whose stored upper address bits equal those of the fetch address, the block reports a taken branch and supplies the stored destination as the next fetch address. In every other case it reports no branch and supplies the sequential address.

A resolution port from the execute stage closes the loop. The execute stage sends the instruction address, whether the instruction was a branch, whether it was taken, and its real destination. It also returns what fetch was told for that instruction: whether it was a hit and, if so, the predicted address. A taken branch that fetch missed is written into the table. A hit whose outcome differs from the prediction removes its table entry. In the cycle after that, the block raises a kill-and-restart request that carries the correct fetch address.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every entry. In the cycle after a reset, `lk_hit` and `flush_req` are 0, and every later lookup misses until an entry is written.
- R2: A lookup issued with `lk_req`=1 is answered in the next cycle. The index is `lk_pc[IDX_W+1:2]` and the tag is `lk_pc[PC_W-1:IDX_W+2]`, where IDX_W = log2(ENTRIES). A hit requires a valid entry whose stored tag equals the full tag, so two addresses that share an index but differ in tag never hit on each other's entry.
- R3: On a hit, `lk_hit`=1, `lk_taken`=1, and `lk_next_pc` equals the stored destination.
- R4: On a miss, `lk_hit`=0, `lk_taken`=0, and `lk_next_pc` equals the looked-up address plus 4. A cycle after `lk_req`=0, `lk_hit` is 0.
- R5: A resolution with `rs_pred_hit`=0, `rs_is_branch`=1 and `rs_taken`=1 writes a valid entry holding the tag of `rs_pc` and the destination `rs_target`. It overwrites whatever entry was at that index.
- R6: A resolution with `rs_pred_hit`=0 that is not a taken branch changes no entry and raises no flush.
- R7: A resolution with `rs_pred_hit`=1 is mispredicted unless `rs_is_branch`=1, `rs_taken`=1 and `rs_target`=`rs_pred_pc`. On a misprediction, `flush_req` is 1 in the next cycle. `flush_pc` is then `rs_target` for a taken branch and `rs_pc`+4 otherwise, and the entry at the index of `rs_pc` becomes invalid.
- R8: A resolution with `rs_pred_hit`=1 that was predicted correctly raises no flush and leaves the entry in place.
- R9: When a lookup and a table update fall in the same cycle, the lookup answers from the contents before the update. The update is visible to lookups issued from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request from fetch |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_hit | output | 1 | Lookup hit (cycle after request) |
| lk_taken | output | 1 | Predicted taken |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| rs_valid | input | 1 | Resolution report present |
| rs_pc | input | PC_W | Address of the resolved instruction |
| rs_is_branch | input | 1 | Instruction was a branch |
| rs_taken | input | 1 | Branch was taken |
| rs_target | input | PC_W | Actual branch destination |
| rs_pred_hit | input | 1 | Fetch had a hit for this instruction |
| rs_pred_pc | input | PC_W | Next address fetch used on that hit |
| flush_req | output | 1 | Kill fetch and restart (cycle after report) |
| flush_pc | output | PC_W | Restart address |

## Verification
The bench builds the block with ENTRIES=8 and PC_W=32. With this small table, random addresses drawn from four tag values collide on the same index often. Aliasing, eviction of one branch by another, and deletion of an entry that was just reallocated therefore all appear many times within a few thousand cycles. Lookups and resolutions are issued in the same cycle at shared indices, which repeatedly exercises the rule that the old contents are read when both touch one index.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_ALLOC  = 2'd1,
    ACT_DELETE = 2'd2
  } btb_act_e;

endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26,
  parameter int PC_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_target,
  input  logic             wr_en,
  input  logic             wr_set,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target
);
  localparam int WORD_W = TAG_W + PC_W;

  logic [WORD_W-1:0]  mem [ENTRIES];
  logic [WORD_W-1:0]  rd_word;
  logic [ENTRIES-1:0] valid_q;

  // Tag and destination storage: one write port, one registered read port
  // that returns the old word on a same-address collision.
  always_ff @(posedge clk) begin
    if (wr_en && wr_set) mem[wr_idx] <= {wr_tag, wr_target};
    if (rd_en)           rd_word     <= mem[rd_idx];
  end

  assign rd_tag    = rd_word[WORD_W-1:PC_W];
  assign rd_target = rd_word[PC_W-1:0];

  // Valid bits live in flops so that reset can clear them in one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= wr_set;
      if (rd_en) rd_valid        <= valid_q[rd_idx];
    end
  end

  a_r7_delete_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_set) |=> !valid_q[$past(wr_idx)]);

  a_r5_alloc_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_set) |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [PC_W-1:0]  rd_target,
  output logic             lk_hit,
  output logic             lk_taken,
  output logic [PC_W-1:0]  lk_next_pc
);
  logic            req_q;
  logic [PC_W-1:0] pc_q;

  // Capture the request alongside the storage read.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      req_q <= lk_req;
      if (lk_req) pc_q <= lk_pc;
    end
  end

  always_comb begin
    lk_hit     = req_q && rd_valid && (rd_tag == pc_q[PC_W-1:IDX_W+2]);
    lk_taken   = lk_hit;
    lk_next_pc = lk_hit ? rd_target : pc_q + PC_W'(4);
  end

  a_r2_hit_needs_req: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_req));

  a_r4_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_hit);

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rs_valid,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic             rs_is_branch,
  input  logic             rs_taken,
  input  logic [PC_W-1:0]  rs_target,
  input  logic             rs_pred_hit,
  input  logic [PC_W-1:0]  rs_pred_pc,
  output logic             wr_en,
  output logic             wr_set,
  output logic [IDX_W-1:0] wr_idx,
  output logic [TAG_W-1:0] wr_tag,
  output logic [PC_W-1:0]  wr_target,
  output logic             flush_req,
  output logic [PC_W-1:0]  flush_pc
);
  btb_act_e        act;
  logic            went_taken;
  logic            pred_ok;
  logic [PC_W-1:0] fix_pc;

  always_comb begin
    went_taken = rs_is_branch && rs_taken;
    pred_ok    = went_taken && (rs_target == rs_pred_pc);
    fix_pc     = went_taken ? rs_target : rs_pc + PC_W'(4);
    act        = ACT_NONE;
    if (rs_valid) begin
      if (rs_pred_hit && !pred_ok)     act = ACT_DELETE;
      else if (!rs_pred_hit && went_taken) act = ACT_ALLOC;
    end
  end

  assign wr_en     = (act != ACT_NONE);
  assign wr_set    = (act == ACT_ALLOC);
  assign wr_idx    = rs_pc[IDX_W+1:2];
  assign wr_tag    = rs_pc[PC_W-1:IDX_W+2];
  assign wr_target = rs_target;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_req <= 1'b0;
      flush_pc  <= '0;
    end else begin
      flush_req <= (act == ACT_DELETE);
      if (act == ACT_DELETE) flush_pc <= fix_pc;
    end
  end

  a_r6_miss_no_flush: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !rs_pred_hit) |=> !flush_req);

  a_r8_correct_no_flush: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_pred_hit && rs_is_branch && rs_taken && rs_target == rs_pred_pc)
    |=> !flush_req);

  a_r7_bad_not_taken_flush: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && rs_pred_hit && !rs_taken) |=> (flush_req && flush_pc == $past(rs_pc) + PC_W'(4)));

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_req,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_next_pc,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_is_branch,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic            rs_pred_hit,
  input  logic [PC_W-1:0] rs_pred_pc,
  output logic            flush_req,
  output logic [PC_W-1:0] flush_pc
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [PC_W-1:0]  rd_target;
  logic             wr_en;
  logic             wr_set;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic [PC_W-1:0]  wr_target;

  btb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) store_i (
    .clk(clk), .rst(rst),
    .rd_en(lk_req), .rd_idx(lk_pc[IDX_W+1:2]),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_target(rd_target),
    .wr_en(wr_en), .wr_set(wr_set), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_target(wr_target)
  );

  btb_match #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) match_i (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_pc(lk_pc),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_target(rd_target),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc)
  );

  btb_resolve #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) resolve_i (
    .clk(clk), .rst(rst),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_branch(rs_is_branch),
    .rs_taken(rs_taken), .rs_target(rs_target),
    .rs_pred_hit(rs_pred_hit), .rs_pred_pc(rs_pred_pc),
    .wr_en(wr_en), .wr_set(wr_set), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_target(wr_target),
    .flush_req(flush_req), .flush_pc(flush_pc)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!lk_hit && !flush_req));

  a_r3_hit_is_taken: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_taken);

  a_r7_flush_has_cause: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(rs_valid && rs_pred_hit));

endmodule

// File: tb/btb_predictor_tb_top.sv
module btb_predictor_tb_top;
  localparam int ENT   = 8;
  localparam int IDXW  = 3;
  localparam int PCW   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_req = 0, rs_valid = 0, rs_is_branch = 0, rs_taken = 0, rs_pred_hit = 0;
  logic [PCW-1:0] lk_pc = '0, rs_pc = '0, rs_target = '0, rs_pred_pc = '0;
  logic lk_hit, lk_taken, flush_req;
  logic [PCW-1:0] lk_next_pc, flush_pc;

  int nchk = 0;
  int nerr = 0;

  bit          m_v   [ENT];
  logic [31:0] m_tag [ENT];
  logic [31:0] m_tgt [ENT];

  always #5 clk = ~clk;

  btb_predictor #(.ENTRIES(ENT), .PC_W(PCW)) dut_i (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_pc(lk_pc),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_branch(rs_is_branch),
    .rs_taken(rs_taken), .rs_target(rs_target), .rs_pred_hit(rs_pred_hit),
    .rs_pred_pc(rs_pred_pc), .flush_req(flush_req), .flush_pc(flush_pc)
  );

  function automatic int idx_of(input logic [31:0] pc);
    return int'((pc >> 2) & (ENT - 1));
  endfunction

  function automatic logic [31:0] tag_of(input logic [31:0] pc);
    return pc >> (IDXW + 2);
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < ENT; i++) m_v[i] = 0;
  endtask

  task automatic do_reset(input string rq);
    @(negedge clk);
    rst = 1; lk_req = 0; rs_valid = 0;
    @(posedge clk); @(posedge clk);
    model_clear();
    #1;
    check(rq, "lk_hit after reset", 32'(lk_hit), 0);
    check(rq, "flush_req after reset", 32'(flush_req), 0);
    @(negedge clk);
    rst = 0;
  endtask

  // One cycle: drive at negedge, predict from model, update model at edge, check after edge.
  task automatic cyc(input bit lr, input logic [31:0] lp,
                     input bit rv, input logic [31:0] rp, input bit rb, input bit rt,
                     input logic [31:0] rtg, input bit ph, input logic [31:0] ppc,
                     input string rq);
    bit e_hit, e_fl, tkn;
    logic [31:0] e_npc, e_fpc;
    int li, ri;
    @(negedge clk);
    lk_req = lr; lk_pc = lp;
    rs_valid = rv; rs_pc = rp; rs_is_branch = rb; rs_taken = rt;
    rs_target = rtg; rs_pred_hit = ph; rs_pred_pc = ppc;
    li    = idx_of(lp);
    e_hit = lr && m_v[li] && (m_tag[li] == tag_of(lp));
    e_npc = e_hit ? m_tgt[li] : lp + 4;
    tkn   = rb && rt;
    e_fl  = rv && ph && !(tkn && rtg == ppc);
    e_fpc = tkn ? rtg : rp + 4;
    @(posedge clk);
    ri = idx_of(rp);
    if (rv) begin
      if (e_fl) m_v[ri] = 0;
      else if (!ph && tkn) begin
        m_v[ri] = 1; m_tag[ri] = tag_of(rp); m_tgt[ri] = rtg;
      end
    end
    #1;
    check(rq, "lk_hit", 32'(lk_hit), 32'(e_hit));
    check(rq, "lk_taken", 32'(lk_taken), 32'(e_hit));
    if (lr) check(rq, "lk_next_pc", lk_next_pc, e_npc);
    check(rq, "flush_req", 32'(flush_req), 32'(e_fl));
    if (e_fl) check(rq, "flush_pc", flush_pc, e_fpc);
  endtask

  localparam logic [31:0] PCA = 32'h0000_1010;
  localparam logic [31:0] PCB = 32'h0000_1110;

  logic [31:0] pool [4] = '{32'h0000_0040, 32'h0000_0200, 32'h0001_0000, 32'h00AB_0000};

  function automatic logic [31:0] rnd_pc();
    return pool[$urandom_range(0, 3)] | (32'($urandom_range(0, ENT - 1)) << 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset("R1");
    cyc(1, PCA, 0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(0, 0, 1, PCA, 1, 0, 32'h2000, 0, 0, "R6");
    cyc(1, PCA, 1, PCA, 0, 1, 32'h2000, 0, 0, "R6");
    cyc(1, PCA, 0, 0, 0, 0, 0, 0, 0, "R6");
    // Same-cycle allocate and lookup: old contents seen
    cyc(1, PCA, 1, PCA, 1, 1, 32'h2000, 0, 0, "R9");
    cyc(1, PCA, 0, 0, 0, 0, 0, 0, 0, "R5");
    cyc(1, PCB, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(0, PCB, 0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, PCA, 1, PCA, 1, 1, 32'h2000, 1, 32'h2000, "R8");
    cyc(1, PCA, 0, 0, 0, 0, 0, 0, 0, "R3");
    // Same-cycle delete and lookup: old hit still reported
    cyc(1, PCA, 1, PCA, 1, 0, 32'h2000, 1, 32'h2000, "R9");
    cyc(1, PCA, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 1, PCA, 1, 1, 32'h3000, 0, 0, "R5");
    cyc(0, 0, 1, PCA, 1, 1, 32'h3400, 1, 32'h3000, "R7");
    cyc(1, PCA, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 1, PCA, 1, 1, 32'h5000, 0, 0, "R5");
    cyc(0, 0, 1, PCA, 0, 0, 32'h5000, 1, 32'h5000, "R7");
    cyc(0, 0, 1, PCB, 1, 1, 32'h4000, 0, 0, "R5");
    cyc(1, PCB, 0, 0, 0, 0, 0, 0, 0, "R3");
    cyc(1, PCA, 0, 0, 0, 0, 0, 0, 0, "R2");
    do_reset("R1");
    cyc(1, PCB, 0, 0, 0, 0, 0, 0, 0, "R1");

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] p, q, t, pp;
      bit ph;
      p  = rnd_pc();
      q  = rnd_pc();
      t  = 32'h0000_8000 | (32'($urandom_range(0, 3)) << 4);
      ph = ($urandom_range(0, 1) == 1);
      pp = ($urandom_range(0, 2) != 0) ? t : t ^ 32'h40;
      cyc($urandom_range(0, 3) != 0, p, $urandom_range(0, 1) == 1, q,
          $urandom_range(0, 4) != 0, $urandom_range(0, 3) != 0, t, ph, pp,
          "R2/R3/R4/R5/R6/R7/R8/R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

endmodule